// File: doc/BRIEF.md
# Stream-to-Video Output with Timing Lock

This block turns an incoming AXI4-Stream of 24-bit RGB pixels into parallel video with sync, active-video and pixel outputs. It does not own the video timing. An external timing generator supplies horizontal sync, vertical sync, active-video and a first-pixel-of-frame marker, and this block drives that generator's clock enable. Because the pipeline has no frame store, the stream must arrive as unbroken active lines. The block then consumes exactly one beat for every active output cycle. Start of frame is carried on TUSER and end of line on TLAST.

After reset, and after any loss of alignment, the block lets the generator run until it reaches the first pixel of a frame. It then parks the generator there and throws away stream beats until one with TUSER arrives. That beat is shown as pixel (0,0), the generator is released and the block runs locked. While locked, the block checks every consumed beat against the line and frame position. These faults break the lock, and the block resynchronises on the next frame:

- a misplaced TLAST;
- a misplaced or missing TUSER;
- a missing beat in the active area.

Top module: `s2v_video_out`

## Requirements
- R1: During reset and in the first cycle after it, `locked`, `lock_lost`, `vid_active`, `vid_hsync`, `vid_vsync` and `vid_rgb` are all zero.
- R2: `vid_hsync` and `vid_vsync` repeat `tg_hsync` and `tg_vsync` with exactly one cycle of delay, in every state.
- R3: Whenever `vid_active` is low, `vid_rgb` is zero.
- R4: While unlocked, beats without TUSER are accepted and dropped. The block locks on the first TUSER beat taken while the generator is parked at its first pixel. That beat appears one cycle later as active pixel (0,0).
- R5: While unlocked and parked, `gen_en` stays low as long as no TUSER beat is offered, so the generator stays at its first-pixel position (`tg_first` high).
- R6: While locked, each active generator cycle with a valid beat consumes that beat. One cycle later, `vid_active` is high and `vid_rgb` equals that beat's TDATA. A locked frame therefore shows exactly H_ACTIVE×V_ACTIVE active pixels.
- R7: While locked, `s_tready` equals `tg_active`: the stream is stalled during blanking.
- R8: While locked, a TLAST on any pixel other than the last of a line, or a missing TLAST on the last pixel, raises `lock_lost` for one cycle, and `locked` falls in that same cycle.
- R9: While locked, a TUSER on any pixel other than the first of a frame, or a missing TUSER on that first pixel, causes the same loss of lock.
- R10: While locked, an active generator cycle with TVALID low (a gap in the stream) causes the same loss of lock.
- R11: After a loss of lock, the block locks again on a later frame without any outside help. Each single fault yields exactly one `lock_lost` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | PIX_W | Stream pixel, RGB |
| s_tvalid | input | 1 | Stream beat valid |
| s_tuser | input | 1 | Stream start of frame |
| s_tlast | input | 1 | Stream end of line |
| s_tready | output | 1 | Stream ready |
| tg_hsync | input | 1 | Generator horizontal sync |
| tg_vsync | input | 1 | Generator vertical sync |
| tg_active | input | 1 | Generator active-video window |
| tg_first | input | 1 | Generator at first active pixel of a frame |
| gen_en | output | 1 | Clock enable to the generator |
| vid_hsync | output | 1 | Output horizontal sync, registered |
| vid_vsync | output | 1 | Output vertical sync, registered |
| vid_active | output | 1 | Output active video, registered |
| vid_rgb | output | PIX_W | Output pixel, zero outside active video |
| locked | output | 1 | Timing currently aligned |
| lock_lost | output | 1 | One-cycle pulse on loss of alignment |

## Verification
The bench builds the block with an 8×4 active area inside a 12×6 total raster, in place of the default 1280×800. Many full frames, line ends and frame wraps then fit into a few thousand cycles. At this size the bench can also place each fault at a chosen row and column: an early TLAST, a dropped TLAST, a mid-frame TUSER, a missing TUSER and a one-cycle stream gap. After each fault it watches the block resynchronise. The bench's own generator model honours `gen_en`, so the parked-generator behaviour is observed at the raster position itself.

// File: rtl/s2v_pkg.sv
package s2v_pkg;
  // Lock controller states: search for origin, hold at origin, aligned.
  typedef enum logic [1:0] {
    ST_SEEK = 2'd0,
    ST_PARK = 2'd1,
    ST_RUN  = 2'd2
  } lock_state_e;
endpackage

// File: rtl/s2v_lock_fsm.sv
module s2v_lock_fsm
  import s2v_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tg_first,
  input  logic tg_active,
  input  logic s_tvalid,
  input  logic s_tuser,
  input  logic mismatch,
  output logic gen_en,
  output logic s_tready,
  output logic take_first,
  output logic locked,
  output logic lock_lost
);
  lock_state_e st_q, st_d;

  logic in_seek, in_park, in_run;
  assign in_seek = (st_q == ST_SEEK);
  assign in_park = (st_q == ST_PARK);
  assign in_run  = (st_q == ST_RUN);

  // Origin beat accepted while the generator is parked.
  assign take_first = in_park & s_tvalid & s_tuser;

  // Seek: run until origin. Park: freeze until a frame start. Run: free.
  assign gen_en   = in_run | (in_seek & ~tg_first) | take_first;
  // Unlocked: drain everything. Locked: one beat per active cycle.
  assign s_tready = in_run ? tg_active : 1'b1;
  assign locked   = in_run;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SEEK: if (tg_first) st_d = ST_PARK;
      ST_PARK: if (s_tvalid && s_tuser) st_d = ST_RUN;
      ST_RUN:  if (mismatch) st_d = ST_SEEK;
      default: st_d = ST_SEEK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_SEEK;
      lock_lost <= 1'b0;
    end else begin
      st_q      <= st_d;
      lock_lost <= in_run & mismatch;
    end
  end

  // R5
  park_origin_chk: assert property (@(posedge clk) disable iff (rst)
    in_park |-> tg_first);

  // R8
  lost_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    lock_lost |-> (st_q == ST_SEEK));
endmodule

// File: rtl/s2v_line_track.sv
module s2v_line_track #(
  parameter int H_ACTIVE = 1280,
  parameter int V_ACTIVE = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic take_first,
  input  logic take_run,
  input  logic s_tvalid,
  input  logic s_tuser,
  input  logic s_tlast,
  output logic mismatch
);
  localparam int COL_W = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1;
  localparam int ROW_W = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_ACTIVE - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_ACTIVE - 1);

  logic [COL_W-1:0] col_q, base_col;
  logic [ROW_W-1:0] row_q, base_row;
  logic at_origin, at_eol;

  assign at_origin = (col_q == '0) && (row_q == '0);
  assign at_eol    = (col_q == COL_LAST);

  // Every locked active cycle must carry a beat whose markers match.
  assign mismatch = take_run &
                    (~s_tvalid | (s_tuser != at_origin) | (s_tlast != at_eol));

  // The origin beat is stepped from (0,0); locked beats from the counters.
  assign base_col = take_first ? '0 : col_q;
  assign base_row = take_first ? '0 : row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (take_first || take_run) begin
      if (base_col == COL_LAST) begin
        col_q <= '0;
        row_q <= (base_row == ROW_LAST) ? '0 : base_row + 1'b1;
      end else begin
        col_q <= base_col + 1'b1;
        row_q <= base_row;
      end
    end
  end
endmodule

// File: rtl/s2v_out_stage.sv
module s2v_out_stage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tg_hsync,
  input  logic             tg_vsync,
  input  logic             show,
  input  logic [PIX_W-1:0] pix,
  output logic             vid_hsync,
  output logic             vid_vsync,
  output logic             vid_active,
  output logic [PIX_W-1:0] vid_rgb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vid_hsync  <= 1'b0;
      vid_vsync  <= 1'b0;
      vid_active <= 1'b0;
      vid_rgb    <= '0;
    end else begin
      vid_hsync  <= tg_hsync;
      vid_vsync  <= tg_vsync;
      vid_active <= show;
      vid_rgb    <= show ? pix : '0;
    end
  end

  // R3
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !vid_active |-> (vid_rgb == '0));
endmodule

// File: rtl/s2v_video_out.sv
module s2v_video_out #(
  parameter int H_ACTIVE = 1280,
  parameter int V_ACTIVE = 800,
  parameter int PIX_W    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] s_tdata,
  input  logic             s_tvalid,
  input  logic             s_tuser,
  input  logic             s_tlast,
  output logic             s_tready,
  input  logic             tg_hsync,
  input  logic             tg_vsync,
  input  logic             tg_active,
  input  logic             tg_first,
  output logic             gen_en,
  output logic             vid_hsync,
  output logic             vid_vsync,
  output logic             vid_active,
  output logic [PIX_W-1:0] vid_rgb,
  output logic             locked,
  output logic             lock_lost
);
  logic take_first, take_run, mismatch, show;

  assign take_run = locked & tg_active;
  assign show     = (take_first | take_run) & s_tvalid;

  s2v_lock_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tg_first   (tg_first),
    .tg_active  (tg_active),
    .s_tvalid   (s_tvalid),
    .s_tuser    (s_tuser),
    .mismatch   (mismatch),
    .gen_en     (gen_en),
    .s_tready   (s_tready),
    .take_first (take_first),
    .locked     (locked),
    .lock_lost  (lock_lost)
  );

  s2v_line_track #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .take_first (take_first),
    .take_run   (take_run),
    .s_tvalid   (s_tvalid),
    .s_tuser    (s_tuser),
    .s_tlast    (s_tlast),
    .mismatch   (mismatch)
  );

  s2v_out_stage #(
    .PIX_W (PIX_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .tg_hsync   (tg_hsync),
    .tg_vsync   (tg_vsync),
    .show       (show),
    .pix        (s_tdata),
    .vid_hsync  (vid_hsync),
    .vid_vsync  (vid_vsync),
    .vid_active (vid_active),
    .vid_rgb    (vid_rgb)
  );

  // R4
  lock_on_sof_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(s_tvalid && s_tuser && s_tready));

  // R6
  show_on_take_chk: assert property (@(posedge clk) disable iff (rst)
    vid_active |-> $past(s_tvalid && s_tready));

  // R7
  ready_window_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && s_tready) |-> tg_active);
endmodule

// File: tb/test_s2v_video_out.sv
module test_s2v_video_out;
  localparam int CLK_PERIOD = 10;
  localparam int HA = 8;
  localparam int VA = 4;
  localparam int HT = 12;
  localparam int VT = 6;
  localparam int FRAME = HT * VT;
  localparam int NSCN = 6;
  // kind, row, col, expected lock_lost pulses
  // kind 0 clean, 1 early TLAST, 2 mid-frame TUSER, 3 missing TLAST,
  // 4 stream gap, 5 missing TUSER
  localparam int SCN [NSCN][4] = '{
    '{0, 0, 0, 0},
    '{1, 1, 3, 1},
    '{3, 2, 7, 1},
    '{2, 2, 0, 1},
    '{4, 1, 5, 1},
    '{5, 0, 0, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [23:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
  logic s_tready, gen_en;
  logic tg_hsync, tg_vsync, tg_active, tg_first;
  logic vid_hsync, vid_vsync, vid_active, locked, lock_lost;
  logic [23:0] vid_rgb;

  s2v_video_out #(.H_ACTIVE(HA), .V_ACTIVE(VA), .PIX_W(24)) i_s2v_video_out (
    .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tuser(s_tuser), .s_tlast(s_tlast), .s_tready(s_tready),
    .tg_hsync(tg_hsync), .tg_vsync(tg_vsync), .tg_active(tg_active),
    .tg_first(tg_first), .gen_en(gen_en), .vid_hsync(vid_hsync),
    .vid_vsync(vid_vsync), .vid_active(vid_active), .vid_rgb(vid_rgb),
    .locked(locked), .lock_lost(lock_lost)
  );

  // Timing generator model with clock enable
  int gh = 0, gv = 0;
  always @(posedge clk) begin
    if (rst) begin
      gh <= 0; gv <= 0;
    end else if (gen_en) begin
      if (gh == HT - 1) begin
        gh <= 0;
        gv <= (gv == VT - 1) ? 0 : gv + 1;
      end else gh <= gh + 1;
    end
  end
  always_comb begin
    tg_active = (gh < HA) && (gv < VA);
    tg_first  = (gh == 0) && (gv == 0);
    tg_hsync  = (gh == HA + 1) || (gh == HA + 2);
    tg_vsync  = (gv == VA + 1);
  end

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stream source and monitor
  bit src_en = 0, mon_en = 0, fire = 0, cur_inj = 0, inj_pend = 0;
  int sr = 0, sc = 0, inj_kind = 0, inj_r = 0, inj_c = 0;
  bit p_exp = 0, p_hs = 0, p_vs = 0;
  int p_row = 0, p_col = 0, loss_cnt = 0, act_cnt = 0;

  always @(negedge clk) begin
    if (!rst && mon_en) begin
      // R2
      check(vid_hsync == p_hs && vid_vsync == p_vs, "R2 sync delay",
            {vid_hsync, vid_vsync}, {p_hs, p_vs});
      if (p_exp) begin
        // R6
        check(vid_active == 1'b1, "R6 active", vid_active, 1);
        check(vid_rgb == {8'h5A, 8'(p_row), 8'(p_col)}, "R6 pixel",
              vid_rgb, {8'h5A, 8'(p_row), 8'(p_col)});
        act_cnt++;
      end else begin
        check(vid_active == 1'b0, "R6 no active", vid_active, 0);
        // R3
        check(vid_rgb == 24'h0, "R3 blank zero", vid_rgb, 0);
      end
      if (lock_lost) loss_cnt++;
    end
    // advance
    if (cur_inj && (inj_kind == 4 || fire)) inj_pend = 0;
    if (fire) begin
      if (sc == HA - 1) begin
        sc = 0;
        sr = (sr == VA - 1) ? 0 : sr + 1;
      end else sc = sc + 1;
    end
    // drive
    cur_inj = inj_pend && sr == inj_r && sc == inj_c;
    if (!src_en || (cur_inj && inj_kind == 4)) begin
      s_tvalid = 0; s_tuser = 0; s_tlast = 0; s_tdata = '0;
    end else begin
      s_tvalid = 1;
      s_tdata  = {8'h5A, 8'(sr), 8'(sc)};
      s_tuser  = (sr == 0 && sc == 0);
      s_tlast  = (sc == HA - 1);
      if (cur_inj && inj_kind == 1) s_tlast = 1;
      if (cur_inj && inj_kind == 3) s_tlast = 0;
      if (cur_inj && inj_kind == 2) s_tuser = 1;
      if (cur_inj && inj_kind == 5) s_tuser = 0;
    end
    #1;
    fire  = s_tvalid && s_tready;
    p_exp = tg_active && s_tvalid && (locked || (tg_first && gen_en));
    p_row = gv; p_col = gh; p_hs = tg_hsync; p_vs = tg_vsync;
    // R7
    if (!rst && mon_en && locked)
      check(s_tready == tg_active, "R7 ready window", s_tready, tg_active);
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    // R1
    check(locked == 0 && lock_lost == 0, "R1 reset status", {locked, lock_lost}, 0);
    check(vid_active == 0 && vid_rgb == 0, "R1 reset video", vid_rgb, 0);
    check(vid_hsync == 0 && vid_vsync == 0, "R1 reset sync", {vid_hsync, vid_vsync}, 0);
    rst = 0;
    @(negedge clk); #2;
    check(locked == 0 && vid_active == 0 && vid_rgb == 0, "R1 after reset", vid_rgb, 0);
    repeat (2) @(negedge clk);
    mon_en = 1;

    // R5: no stream, generator must stay parked at origin
    repeat (30) @(negedge clk);
    #2;
    check(gen_en == 0, "R5 gen held", gen_en, 0);
    check(gh == 0 && gv == 0, "R5 origin position", gh + gv * 256, 0);
    check(locked == 0, "R5 unlocked", locked, 0);

    // R4: start mid-frame, expect drop then lock on TUSER
    sr = 1; sc = 2; src_en = 1;
    for (int k = 0; k < 300 && !locked; k++) @(negedge clk);
    #2;
    check(locked == 1, "R4 lock acquired", locked, 1);

    // R6: one locked frame shows exactly HA*VA pixels
    @(negedge clk); #2;
    act_cnt = 0;
    repeat (FRAME) @(negedge clk);
    #2;
    check(act_cnt == HA * VA, "R6 pixels per frame", act_cnt, HA * VA);

    for (int i = 0; i < NSCN; i++) begin
      for (int k = 0; k < 400 && !locked; k++) @(negedge clk);
      #2;
      loss_cnt = 0;
      if (SCN[i][0] != 0) begin
        inj_kind = SCN[i][0]; inj_r = SCN[i][1]; inj_c = SCN[i][2];
        inj_pend = 1;
        for (int k = 0; k < 400 && inj_pend; k++) @(negedge clk);
        #2;
        check(!inj_pend, "R8 R9 R10 fault injected", inj_pend, 0);
      end
      repeat (3 * FRAME) @(negedge clk);
      #2;
      case (SCN[i][0])
        1, 3:    check(loss_cnt == SCN[i][3], "R8 TLAST fault", loss_cnt, SCN[i][3]);
        2, 5:    check(loss_cnt == SCN[i][3], "R9 TUSER fault", loss_cnt, SCN[i][3]);
        4:       check(loss_cnt == SCN[i][3], "R10 gap fault", loss_cnt, SCN[i][3]);
        default: check(loss_cnt == SCN[i][3], "R6 clean frames", loss_cnt, SCN[i][3]);
      endcase
      // R11
      check(locked == 1, "R11 relocked", locked, 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule